// File: doc/BRIEF.md
# Two-Bank Prioritised Interrupt Controller

This block gathers a set of interrupt request lines and presents them to a processor as two independent request outputs: a normal bank and a fast bank. Both banks share one stage of per-source conditioning. That stage selects the polarity of each line and chooses whether the request follows the line level or is captured until software acknowledges it. Each bank then applies its own enable mask and its own priority threshold. A combinational search names the single most urgent pending source in each bank.

Software reaches every register through a word-addressed register port. Each access is a single-cycle write or read strobe, and read data is registered and appears one cycle after the strobe. A typical service loop has four steps. It reads a bank's masked status. While that status is nonzero, it reads the bank's current-source register and handles that source. It then reads the bank's acknowledge register, which releases the captured requests of that bank.

Top module: `irqc_dual_bank`

## Requirements
- R1: After reset, both enable masks are 0, both thresholds are 0xF, the polarity select (0x200) is all ones, the capture select (0x204) is 0, every priority is 0, both request outputs are low and the read data is 0.
- R2: Bank offset +0x08 sets the mask bits written as 1 and +0x0C clears the mask bits written as 1. Neither offset changes any other mask bit. A read at either offset returns the mask.
- R3: Raw status at bank offset +0x04 shows the conditioned pending bits before masking. Polarity select bit i at 0x200 passes line i unchanged when 1 and inverts it when 0.
- R4: When capture select bit i at 0x204 is 1, a conditioned request on source i stays pending in each bank, even after the line drops, until that bank is acknowledged. When the bit is 0, pending follows the level.
- R5: A read of bank offset +0x28 returns that bank's masked status and, on the same edge, clears only that bank's captured requests. A source whose conditioned level is still active remains pending.
- R6: Masked status at bank offset +0x00 equals raw status AND enable mask AND the threshold pass bit. Each request output (irq_req for bank 0x000, fiq_req for bank 0x100) is high exactly when its masked status is nonzero.
- R7: The current-source register at bank offset +0x20 returns the index of the masked-pending source with the smallest priority value. Among equal priority values the lowest index wins. It reads 0 when nothing is pending.
- R8: The threshold at bank offset +0x2C is 4 bits wide. A source whose priority value exceeds it is excluded from masked status, from the request output and from the current-source register.
- R9: The 4-bit priority of source i is stored at 0x300 + 4*i, with 0 as the most urgent value, and reads back in the low bits.
- R10: Read data changes only in the cycle after a read strobe. Unmapped addresses read 0, and writes to status, raw-status, current or acknowledge offsets have no effect.
- R11: The two banks keep separate masks, thresholds and captured requests. A write or acknowledge to one bank leaves the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | NUM_SRC | Raw interrupt request lines |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after bus_rd |
| irq_req | output | 1 | Request output of the normal bank |
| fiq_req | output | 1 | Request output of the fast bank |

## Verification
The bench builds the controller with its default parameters: 32 sources, 4-bit priorities, a 32-bit data word and a 12-bit address. These values let it reach the top source indices 30 and 31 and the full 0xF threshold. They also let it program every priority through the 0x300 window. The defaults expose the lowest-index tie rule at both ends of the source range. The full-width mask writes of all ones and the full 32-bit polarity word are also covered at their real width.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // offsets inside one bank window
   localparam logic [7:0] OFF_STATUS  = 8'h00;
   localparam logic [7:0] OFF_RAW     = 8'h04;
   localparam logic [7:0] OFF_EN_SET  = 8'h08;
   localparam logic [7:0] OFF_EN_CLR  = 8'h0C;
   localparam logic [7:0] OFF_CURRENT = 8'h20;
   localparam logic [7:0] OFF_ACK     = 8'h28;
   localparam logic [7:0] OFF_THRESH  = 8'h2C;

   // offsets inside the shared conditioning window (region 2)
   localparam logic [7:0] OFF_POLSEL  = 8'h00;
   localparam logic [7:0] OFF_CAPSEL  = 8'h04;

   // 256-byte regions selected by the address bits above bit 7
   localparam int REGION_BANK0 = 0;
   localparam int REGION_BANK1 = 1;
   localparam int REGION_COND  = 2;
   localparam int REGION_PRIO  = 3;

   localparam int NUM_BANKS = 2;

endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]             cand,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   output logic [IDX_W-1:0]               win_idx,
   output logic                           win_found
);

   logic [PRIO_W-1:0] best_prio;

   // scan from the top index downward; "<=" lets a lower index replace an
   // equal-priority winner, so ties resolve to the smallest index
   always_comb begin
      win_idx   = '0;
      win_found = 1'b0;
      best_prio = '1;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand[i] && (!win_found || prio[i] <= best_prio)) begin
            win_idx   = IDX_W'(i);
            best_prio = prio[i];
            win_found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irqc_src_cond.sv
module irqc_src_cond #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             lines,
   input  logic                           wr_pol,
   input  logic                           wr_cap,
   input  logic [NUM_SRC-1:0]             wr_prio,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_SRC-1:0]             pol_q,
   output logic [NUM_SRC-1:0]             cap_q,
   output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
   output logic [NUM_SRC-1:0]             level
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= '1;
         cap_q <= '0;
      end else begin
         if (wr_pol) pol_q <= wdata[NUM_SRC-1:0];
         if (wr_cap) cap_q <= wdata[NUM_SRC-1:0];
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          prio_q[i] <= '0;
         else if (wr_prio[i]) prio_q[i] <= wdata[PRIO_W-1:0];
      end
      // polarity bit 1 = pass through, 0 = invert
      assign level[i] = lines[i] ^ ~pol_q[i];
   end

   p_prio_write_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_prio) == '0 |-> $stable(prio_q))
      else $error("p_prio_write_r9: priority changed without a write");

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             level,
   input  logic [NUM_SRC-1:0]             capture,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input  logic                           wr_set,
   input  logic                           wr_clr,
   input  logic                           wr_thr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic                           ack,
   output logic [NUM_SRC-1:0]             raw,
   output logic [NUM_SRC-1:0]             masked,
   output logic [NUM_SRC-1:0]             mask_q,
   output logic [PRIO_W-1:0]              thr_q,
   output logic [IDX_W-1:0]               cur_idx,
   output logic                           req
);

   logic [NUM_SRC-1:0] held_q;
   logic [NUM_SRC-1:0] thr_ok;
   logic               found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         thr_q  <= '1;
      end else begin
         if (wr_set) mask_q <= mask_q | wdata[NUM_SRC-1:0];
         if (wr_clr) mask_q <= mask_q & ~wdata[NUM_SRC-1:0];
         if (wr_thr) thr_q  <= wdata[PRIO_W-1:0];
      end
   end

   // captured requests; acknowledge wins on its own edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= '0;
      else if (ack) held_q <= '0;
      else          held_q <= held_q | (level & capture);
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_thr
      assign thr_ok[i] = (prio[i] <= thr_q);
   end

   assign raw    = level | (held_q & capture);
   assign masked = raw & mask_q & thr_ok;
   assign req    = |masked;

   irqc_prio_pick #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W)
   ) u_pick (
      .cand      (masked),
      .prio      (prio),
      .win_idx   (cur_idx),
      .win_found (found)
   );

   p_enable_sets_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_set && !wr_clr |=> (mask_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]))
      else $error("p_enable_sets_r2");

   p_disable_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (mask_q & $past(wdata[NUM_SRC-1:0])) == '0)
      else $error("p_disable_clears_r2");

   p_capture_holds_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ack) && capture == $past(capture)
      |-> (raw & capture & $past(raw)) == ($past(raw) & capture))
      else $error("p_capture_holds_r4");

   p_winner_pending_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      found |-> masked[cur_idx])
      else $error("p_winner_pending_r7");

   p_idle_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> cur_idx == '0)
      else $error("p_idle_zero_r7");

   p_thr_gate_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      req |-> prio[cur_idx] <= thr_q)
      else $error("p_thr_gate_r8");

endmodule

// File: rtl/irqc_dual_bank.sv
module irqc_dual_bank #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lines,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_req,
   output logic               fiq_req
);
   import irqc_pkg::*;

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int RG_W  = ADDR_W - 8;

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_nsrc
      $error("irqc_dual_bank: NUM_SRC must lie in 1..DATA_W");
   end
   if (NUM_SRC > 64) begin : g_bad_prio_window
      $error("irqc_dual_bank: priority window holds at most 64 sources");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio_w
      $error("irqc_dual_bank: PRIO_W must lie in 1..8");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("irqc_dual_bank: ADDR_W must be at least 10");
   end

   logic [RG_W-1:0] region;
   logic [7:0]      offs;
   assign region = bus_addr[ADDR_W-1:8];
   assign offs   = bus_addr[7:0];

   logic                           in_cond, in_prio;
   logic [NUM_SRC-1:0]             wr_prio;
   logic [NUM_SRC-1:0]             pol_q, cap_q, level;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

   assign in_cond = (region == RG_W'(REGION_COND));
   assign in_prio = (region == RG_W'(REGION_PRIO)) && (offs[1:0] == 2'b00);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio_dec
      assign wr_prio[i] = bus_wr && in_prio && (offs[7:2] == 6'(i));
   end

   irqc_src_cond #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .DATA_W  (DATA_W)
   ) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines   (src_lines),
      .wr_pol  (bus_wr && in_cond && offs == OFF_POLSEL),
      .wr_cap  (bus_wr && in_cond && offs == OFF_CAPSEL),
      .wr_prio (wr_prio),
      .wdata   (bus_wdata),
      .pol_q   (pol_q),
      .cap_q   (cap_q),
      .prio_q  (prio_q),
      .level   (level)
   );

   // two banks share the conditioned levels and priorities
   logic [NUM_SRC-1:0] b_raw  [NUM_BANKS];
   logic [NUM_SRC-1:0] b_mskd [NUM_BANKS];
   logic [NUM_SRC-1:0] b_mask [NUM_BANKS];
   logic [PRIO_W-1:0]  b_thr  [NUM_BANKS];
   logic [IDX_W-1:0]   b_cur  [NUM_BANKS];
   logic               b_req  [NUM_BANKS];
   logic               b_hit  [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign b_hit[b] = (region == RG_W'(b));

      irqc_bank #(
         .NUM_SRC (NUM_SRC),
         .PRIO_W  (PRIO_W),
         .DATA_W  (DATA_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .level   (level),
         .capture (cap_q),
         .prio    (prio_q),
         .wr_set  (bus_wr && b_hit[b] && offs == OFF_EN_SET),
         .wr_clr  (bus_wr && b_hit[b] && offs == OFF_EN_CLR),
         .wr_thr  (bus_wr && b_hit[b] && offs == OFF_THRESH),
         .wdata   (bus_wdata),
         .ack     (bus_rd && b_hit[b] && offs == OFF_ACK),
         .raw     (b_raw[b]),
         .masked  (b_mskd[b]),
         .mask_q  (b_mask[b]),
         .thr_q   (b_thr[b]),
         .cur_idx (b_cur[b]),
         .req     (b_req[b])
      );
   end

   assign irq_req = b_req[REGION_BANK0];
   assign fiq_req = b_req[REGION_BANK1];

   // read multiplexer
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (b_hit[b]) begin
            case (offs)
               OFF_STATUS, OFF_ACK:    rd_next = DATA_W'(b_mskd[b]);
               OFF_RAW:                rd_next = DATA_W'(b_raw[b]);
               OFF_EN_SET, OFF_EN_CLR: rd_next = DATA_W'(b_mask[b]);
               OFF_CURRENT:            rd_next = DATA_W'(b_cur[b]);
               OFF_THRESH:             rd_next = DATA_W'(b_thr[b]);
               default:                rd_next = '0;
            endcase
         end
      end
      if (in_cond) begin
         if (offs == OFF_POLSEL) rd_next = DATA_W'(pol_q);
         if (offs == OFF_CAPSEL) rd_next = DATA_W'(cap_q);
      end
      if (in_prio) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (offs[7:2] == 6'(i)) rd_next = DATA_W'(prio_q[i]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   p_rdata_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> $stable(bus_rdata))
      else $error("p_rdata_hold_r10");

   p_irq_from_status_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> b_mask[REGION_BANK0] != '0)
      else $error("p_irq_from_status_r6");

   p_fiq_from_status_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      fiq_req |-> b_mask[REGION_BANK1] != '0)
      else $error("p_fiq_from_status_r6");

endmodule

// File: tb/irqc_dual_bank_test.sv
module irqc_dual_bank_test;

   localparam int N  = 32;
   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_lines = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_req, fiq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irqc_dual_bank #(.NUM_SRC(N), .PRIO_W(4), .DATA_W(DW), .ADDR_W(AW)) uut (
      .clk (clk), .rst_n (rst_n), .src_lines (src_lines),
      .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .irq_req (irq_req), .fiq_req (fiq_req)
   );

   localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_Q = 2'd2;
   localparam int NV = 62;
   // {lines, op, addr, data, expected, requirement}
   localparam logic [117:0] VEC [NV] = '{
      {32'h0, OP_W, 12'h008, 32'hF0, 32'h0, 8'd2},                  // R2 set
      {32'h0, OP_R, 12'h008, 32'h0, 32'hF0, 8'd2},                  // R2
      {32'h0, OP_W, 12'h008, 32'hF00, 32'h0, 8'd2},
      {32'h0, OP_W, 12'h00C, 32'h30, 32'h0, 8'd2},                  // R2 clear
      {32'h0, OP_R, 12'h00C, 32'h0, 32'hFC0, 8'd2},                 // R2
      {32'h0, OP_R, 12'h108, 32'h0, 32'h0, 8'd11},                  // R11
      {32'h40, OP_R, 12'h004, 32'h0, 32'h40, 8'd3},                 // R3
      {32'h40, OP_R, 12'h000, 32'h0, 32'h40, 8'd6},                 // R6
      {32'h40, OP_Q, 12'h000, 32'h0, 32'h1, 8'd6},                  // R6 irq only
      {32'h40, OP_W, 12'h200, 32'hFFFF_FFFE, 32'h0, 8'd3},
      {32'h40, OP_R, 12'h004, 32'h0, 32'h41, 8'd3},                 // R3 invert
      {32'h40, OP_R, 12'h000, 32'h0, 32'h40, 8'd6},                 // R6
      {32'h40, OP_W, 12'h200, 32'hFFFF_FFFF, 32'h0, 8'd3},
      {32'h480, OP_R, 12'h020, 32'h0, 32'h7, 8'd7},                 // R7 tie
      {32'h480, OP_W, 12'h31C, 32'h5, 32'h0, 8'd9},
      {32'h480, OP_R, 12'h31C, 32'h0, 32'h5, 8'd9},                 // R9
      {32'h480, OP_R, 12'h020, 32'h0, 32'hA, 8'd7},                 // R7
      {32'h480, OP_W, 12'h02C, 32'h4, 32'h0, 8'd8},
      {32'h480, OP_W, 12'h328, 32'h9, 32'h0, 8'd9},
      {32'h480, OP_R, 12'h000, 32'h0, 32'h0, 8'd8},                 // R8
      {32'h480, OP_Q, 12'h000, 32'h0, 32'h0, 8'd8},                 // R8
      {32'h480, OP_R, 12'h020, 32'h0, 32'h0, 8'd7},                 // R7 none
      {32'h480, OP_R, 12'h12C, 32'h0, 32'hF, 8'd11},                // R11
      {32'h480, OP_W, 12'h02C, 32'hF, 32'h0, 8'd8},
      {32'h480, OP_R, 12'h020, 32'h0, 32'h7, 8'd7},                 // R7
      {32'h480, OP_R, 12'h02C, 32'h0, 32'hF, 8'd8},                 // R8
      {32'h0, OP_W, 12'h204, 32'h100, 32'h0, 8'd4},
      {32'h0, OP_W, 12'h108, 32'h100, 32'h0, 8'd11},
      {32'h100, OP_R, 12'h004, 32'h0, 32'h100, 8'd4},               // R4
      {32'h0, OP_R, 12'h004, 32'h0, 32'h100, 8'd4},                 // R4 held
      {32'h0, OP_R, 12'h104, 32'h0, 32'h100, 8'd4},
      {32'h0, OP_R, 12'h000, 32'h0, 32'h100, 8'd6},
      {32'h0, OP_Q, 12'h000, 32'h0, 32'h3, 8'd6},
      {32'h0, OP_R, 12'h128, 32'h0, 32'h100, 8'd5},                 // R5 ack
      {32'h0, OP_R, 12'h104, 32'h0, 32'h0, 8'd5},
      {32'h0, OP_R, 12'h004, 32'h0, 32'h100, 8'd11},                // R11
      {32'h0, OP_R, 12'h120, 32'h0, 32'h0, 8'd7},
      {32'h0, OP_R, 12'h028, 32'h0, 32'h100, 8'd5},
      {32'h0, OP_R, 12'h004, 32'h0, 32'h0, 8'd5},
      {32'h40, OP_R, 12'h028, 32'h0, 32'h40, 8'd5},
      {32'h40, OP_R, 12'h004, 32'h0, 32'h40, 8'd5},                 // R5 level stays
      {32'h40, OP_R, 12'h010, 32'h0, 32'h0, 8'd10},                 // R10 unmapped
      {32'h40, OP_W, 12'h000, 32'hFFFF_FFFF, 32'h0, 8'd10},
      {32'h40, OP_R, 12'h000, 32'h0, 32'h40, 8'd10},
      {32'h40, OP_W, 12'h020, 32'h1F, 32'h0, 8'd10},
      {32'h40, OP_R, 12'h020, 32'h0, 32'h6, 8'd10},
      {32'h40, OP_W, 12'h204, 32'h40, 32'h0, 8'd4},
      {32'h40, OP_R, 12'h028, 32'h0, 32'h40, 8'd5},
      {32'h0, OP_R, 12'h004, 32'h0, 32'h40, 8'd4},                  // R4 re-capture
      {32'h0, OP_R, 12'h028, 32'h0, 32'h40, 8'd5},
      {32'h0, OP_R, 12'h004, 32'h0, 32'h0, 8'd5},
      {32'h0, OP_R, 12'h128, 32'h0, 32'h0, 8'd5},
      {32'h0, OP_W, 12'h108, 32'hFFFF_FFFF, 32'h0, 8'd2},
      {32'hC000_0000, OP_R, 12'h120, 32'h0, 32'h1E, 8'd7},          // R7 top tie
      {32'hC000_0000, OP_W, 12'h378, 32'h1, 32'h0, 8'd9},
      {32'hC000_0000, OP_R, 12'h120, 32'h0, 32'h1F, 8'd7},
      {32'hC000_0000, OP_R, 12'h100, 32'h0, 32'hC000_0000, 8'd6},
      {32'hC000_0000, OP_W, 12'h10C, 32'hFFFF_FFFF, 32'h0, 8'd2},
      {32'hC000_0000, OP_R, 12'h108, 32'h0, 32'h0, 8'd2},
      {32'hC000_0000, OP_Q, 12'h000, 32'h0, 32'h0, 8'd6},
      {32'h0, OP_W, 12'h00C, 32'hFFFF_FFFF, 32'h0, 8'd2},
      {32'h0, OP_R, 12'h008, 32'h0, 32'h0, 8'd2}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input int req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic bus_op(input logic [1:0] op, input logic [31:0] lines,
                         input logic [AW-1:0] addr, input logic [31:0] data);
      @(negedge clk);
      src_lines = lines;
      bus_addr  = addr;
      bus_wdata = data;
      bus_wr    = (op == OP_W);
      bus_rd    = (op == OP_R);
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
   endtask

   task automatic rd_check(input logic [AW-1:0] addr, input logic [31:0] exp,
                           input int req);
      bus_op(OP_R, src_lines, addr, 32'h0);
      check(bus_rdata, exp, req, $sformatf("read 0x%03h", addr));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check(bus_rdata, 32'h0, 1, "rdata after reset");
      check({30'h0, fiq_req, irq_req}, 32'h0, 1, "requests after reset");
      rd_check(12'h02C, 32'hF, 1);
      rd_check(12'h12C, 32'hF, 1);
      rd_check(12'h200, 32'hFFFF_FFFF, 1);
      rd_check(12'h204, 32'h0, 1);
      rd_check(12'h108, 32'h0, 1);
      rd_check(12'h37C, 32'h0, 1);

      for (int k = 0; k < NV; k++) begin
         logic [31:0] ln, dt, ex;
         logic [1:0]  op;
         logic [11:0] ad;
         int          rq;
         {ln, op, ad, dt, ex} = VEC[k][117:8];
         rq = int'(VEC[k][7:0]);
         bus_op(op, ln, ad, dt);
         if (op == OP_R)
            check(bus_rdata, ex, rq, $sformatf("vector %0d read 0x%03h", k, ad));
         else if (op == OP_Q)
            check({30'h0, fiq_req, irq_req}, ex, rq, $sformatf("vector %0d requests", k));
      end

      // R1 reset in mid-run returns configuration to defaults
      bus_op(OP_W, 32'h0, 12'h008, 32'h3);
      bus_op(OP_W, 32'h0, 12'h204, 32'h5);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_check(12'h008, 32'h0, 1);
      rd_check(12'h204, 32'h0, 1);
      rd_check(12'h31C, 32'h0, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule